// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation converter. It owns the trial code that feeds the converter's DAC, reads back one comparator bit that says whether the current trial code is above the held input, and settles a 12-bit result by binary search from the most significant bit down. The comparator, the sample-and-hold and the reference live outside the block.

A sequencer wraps the search engine. It selects the input channel, holds a sample phase of fixed length, and then runs one search per conversion. It writes each result into a small result bank at the position the conversion holds within its pass. Four run modes are offered: one channel converted once, one channel converted on every trigger, a channel range converted once, and a channel range converted on every trigger. Each pass is started either by a software strobe or by a timer tick, chosen by a configuration bit. Results are read back through a synchronous read port.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The search starts with the trial code at only the most significant bit set (0x800). Each step clears the bit under trial when `cmp_high` is 1 and sets the next lower bit. With an ideal comparator (`cmp_high` = trial code > held input), the stored result equals the held input, including 0 and 4095.
- R2: A conversion takes one clock per bit. Count rising edges from the one that samples the accepted trigger. The first trial code appears after edge SAMPLE_CYC+1, and `conv_done` is high for one cycle after edge SAMPLE_CYC+RES+1. With the default parameters these are edges 5 and 17.
- R3: `cfg_mode` = 0 (single once) converts `cfg_ch_first` one time and stores the result in slot 0. Further triggers are then ignored until `cfg_en` goes low and high again.
- R4: `cfg_mode` = 1 (single repeated) converts `cfg_ch_first` once per accepted trigger and stays armed while `cfg_en` is high.
- R5: `cfg_mode` = 2 (range once) converts channels `cfg_ch_first` through `cfg_ch_last` in ascending order from one trigger. Result k goes to slot k. `seq_end` pulses once, in the cycle after the last result is stored. `rd_data` shows slot `rd_idx` one clock after `rd_idx` is applied.
- R6: `cfg_mode` = 3 (range repeated) runs the whole range again on each later trigger without re-arming.
- R7: `cfg_trig_sel` = 0 takes `sw_start` as the trigger and ignores `tmr_tick`. `cfg_trig_sel` = 1 takes `tmr_tick` and ignores `sw_start`.
- R8: `busy` rises on trigger acceptance and falls at the edge that stores the last result of the pass. A trigger that arrives while `busy` is high starts nothing and sets the sticky `overrun` flag. The next accepted trigger clears `overrun`.
- R9: Lowering `cfg_en` during a range pass lets the conversion in progress finish and store. No further channel is converted, and `seq_end` does not pulse.
- R10: In range modes with `cfg_ch_last` < `cfg_ch_first`, a pass converts only `cfg_ch_first`.
- R11: After reset, `busy`, `conv_done`, `seq_end`, `overrun`, `sample_en` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enable. A rising edge arms the sequencer; a low level stops it after the current conversion |
| cfg_mode | input | 2 | 0 single once, 1 single repeated, 2 range once, 3 range repeated |
| cfg_trig_sel | input | 1 | Trigger source: 0 software strobe, 1 timer tick |
| cfg_ch_first | input | CHW | First channel of a pass |
| cfg_ch_last | input | CHW | Last channel of a range pass |
| sw_start | input | 1 | Software start strobe |
| tmr_tick | input | 1 | Timer trigger tick |
| cmp_high | input | 1 | Comparator: 1 when the trial code is above the held input |
| dac_code | output | RES | Trial code to the DAC; 0 outside a search |
| ch_sel | output | CHW | Selected input channel |
| sample_en | output | 1 | High during the sample phase |
| conv_done | output | 1 | One-cycle pulse as a result is produced |
| seq_end | output | 1 | One-cycle pulse after a pass completes in full |
| busy | output | 1 | Pass in progress |
| overrun | output | 1 | Sticky flag: a trigger arrived while busy |
| rd_idx | input | CHW | Result slot to read |
| rd_data | output | RES | Result slot contents, one clock after rd_idx |

## Verification
A wrong bit counter or a wrong trial update shows up first on `dac_code`, in the cycles right after the sample phase ends. The stored result then differs from the channel's held input, and that difference is visible once the pass ends and the slot is read. A fault in the channel stepping or slot indexing shows at `ch_sel` during `conv_done`, or as values read back from the wrong slots, within one pass. A fault in arming, trigger selection or the busy window shows within a few cycles of a trigger, as a pass that should not start, a `busy` that never rises, or an `overrun` flag in the wrong state.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ONE     = 2'd0,
    MODE_ONE_RPT = 2'd1,
    MODE_SEQ     = 2'd2,
    MODE_SEQ_RPT = 2'd3
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_trial_engine.sv
module sar_trial_engine #(
  parameter int RES = 12,
  localparam int IW = $clog2(RES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           cmp_high,
  output logic [RES-1:0] code_q,
  output logic           res_valid,
  output logic [RES-1:0] res_data
);
  logic [IW-1:0]  bit_q;
  logic           active_q;
  logic [RES-1:0] nxt;

  // trial update: drop the bit under test if too high, then try the next one
  always_comb begin
    nxt = code_q;
    if (cmp_high) nxt[bit_q] = 1'b0;
    if (bit_q != '0) nxt[bit_q - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      bit_q     <= '0;
      active_q  <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        code_q   <= RES'(1) << (RES - 1);
        bit_q    <= IW'(RES - 1);
        active_q <= 1'b1;
      end else if (active_q) begin
        if (bit_q == '0) begin
          res_data  <= nxt;
          res_valid <= 1'b1;
          active_q  <= 1'b0;
          code_q    <= '0;
        end else begin
          code_q <= nxt;
          bit_q  <= bit_q - IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int RES   = 12,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [RES-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [RES-1:0] rdata
);
  logic [RES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int SAMPLE_CYC = 4,
  localparam int CHW       = $clog2(NCH),
  localparam int SCW       = $clog2(SAMPLE_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_trig_sel,
  input  logic [CHW-1:0] cfg_ch_first,
  input  logic [CHW-1:0] cfg_ch_last,
  input  logic           sw_start,
  input  logic           tmr_tick,
  input  logic           res_valid,
  output logic           conv_go,
  output logic           wr_en,
  output logic [CHW-1:0] wr_idx,
  output logic [CHW-1:0] ch_sel,
  output logic           sample_en,
  output logic           busy,
  output logic           seq_end,
  output logic           overrun
);
  seq_state_e     state;
  conv_mode_e     mode_q;
  logic [SCW-1:0] samp_cnt;
  logic [CHW-1:0] last_q;
  logic [CHW-1:0] pos_q;
  logic           armed;
  logic           en_q;
  logic           trig;
  logic           accept;
  logic           samp_last;
  logic           range_left;

  assign trig       = cfg_trig_sel ? tmr_tick : sw_start;
  assign accept     = (state == ST_IDLE) && cfg_en && armed && trig;
  assign samp_last  = (state == ST_SAMPLE) && (samp_cnt == SCW'(SAMPLE_CYC - 1));
  assign range_left = mode_q[1] && (ch_sel < last_q);
  assign conv_go    = samp_last;
  assign wr_en      = res_valid && (state == ST_CONV);
  assign wr_idx     = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= MODE_ONE;
      samp_cnt  <= '0;
      last_q    <= '0;
      pos_q     <= '0;
      ch_sel    <= '0;
      armed     <= 1'b0;
      en_q      <= 1'b0;
      sample_en <= 1'b0;
      busy      <= 1'b0;
      seq_end   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      en_q    <= cfg_en;
      seq_end <= 1'b0;
      if (cfg_en && !en_q) armed <= 1'b1;
      if (busy && trig) overrun <= 1'b1;
      unique case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_SAMPLE;
          mode_q    <= conv_mode_e'(cfg_mode);
          last_q    <= cfg_ch_last;
          ch_sel    <= cfg_ch_first;
          pos_q     <= '0;
          samp_cnt  <= '0;
          sample_en <= 1'b1;
          busy      <= 1'b1;
          overrun   <= 1'b0;
        end
        ST_SAMPLE: begin
          if (samp_last) begin
            state     <= ST_CONV;
            sample_en <= 1'b0;
          end else begin
            samp_cnt <= samp_cnt + SCW'(1);
          end
        end
        ST_CONV: if (res_valid) begin
          if (range_left && cfg_en) begin
            ch_sel    <= ch_sel + CHW'(1);
            pos_q     <= pos_q + CHW'(1);
            samp_cnt  <= '0;
            sample_en <= 1'b1;
            state     <= ST_SAMPLE;
          end else begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            seq_end <= !range_left;
            if (!mode_q[0]) armed <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES        = 12,
  parameter int NCH        = 8,
  parameter int SAMPLE_CYC = 4,
  localparam int CHW       = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_trig_sel,
  input  logic [CHW-1:0] cfg_ch_first,
  input  logic [CHW-1:0] cfg_ch_last,
  input  logic           sw_start,
  input  logic           tmr_tick,
  input  logic           cmp_high,
  output logic [RES-1:0] dac_code,
  output logic [CHW-1:0] ch_sel,
  output logic           sample_en,
  output logic           conv_done,
  output logic           seq_end,
  output logic           busy,
  output logic           overrun,
  input  logic [CHW-1:0] rd_idx,
  output logic [RES-1:0] rd_data
);
  logic           conv_go;
  logic           wr_en;
  logic [CHW-1:0] wr_idx;
  logic [RES-1:0] res_data;

  sar_seq_fsm #(.NCH(NCH), .SAMPLE_CYC(SAMPLE_CYC)) u_fsm (
    .clk, .rst, .cfg_en, .cfg_mode, .cfg_trig_sel, .cfg_ch_first, .cfg_ch_last,
    .sw_start, .tmr_tick, .res_valid(conv_done), .conv_go, .wr_en, .wr_idx,
    .ch_sel, .sample_en, .busy, .seq_end, .overrun
  );

  sar_trial_engine #(.RES(RES)) u_eng (
    .clk, .rst, .start(conv_go), .cmp_high, .code_q(dac_code),
    .res_valid(conv_done), .res_data
  );

  sar_result_bank #(.RES(RES), .DEPTH(NCH)) u_bank (
    .clk, .we(wr_en), .waddr(wr_idx), .wdata(res_data),
    .raddr(rd_idx), .rdata(rd_data)
  );
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_en,
  input logic           cfg_trig_sel,
  input logic           sw_start,
  input logic           tmr_tick,
  input logic [RES-1:0] dac_code,
  input logic           sample_en,
  input logic           conv_done,
  input logic           seq_end,
  input logic           busy,
  input logic           overrun
);
  // R1
  sample_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> dac_code == '0);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !conv_done);

  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> busy);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(conv_done));

  // R5
  seq_end_chk: assert property (@(posedge clk) disable iff (rst)
    seq_end |-> !busy && $past(conv_done));

  // R7
  accept_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cfg_en) && $past(cfg_trig_sel ? tmr_tick : sw_start));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    busy && (cfg_trig_sel ? tmr_tick : sw_start) |=> overrun);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES(RES)) u_chk (.*);

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;
  localparam int CLK_P = 10;
  localparam int RES = 12;
  localparam int NCH = 8;
  localparam int SAMPLE_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_trig_sel = 1'b0;
  logic [2:0] cfg_ch_first = 3'd0;
  logic [2:0] cfg_ch_last = 3'd0;
  logic sw_start = 1'b0;
  logic tmr_tick = 1'b0;
  logic cmp_high;
  logic [RES-1:0] dac_code;
  logic [2:0] ch_sel;
  logic sample_en, conv_done, seq_end, busy, overrun;
  logic [2:0] rd_idx = 3'd0;
  logic [RES-1:0] rd_data;

  logic [RES-1:0] vin [NCH];
  int total = 0;
  int bad = 0;
  int ncv = 0;
  int nse = 0;
  int log_ch [1024];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  assign cmp_high = dac_code > vin[ch_sel];

  sar_seq_ctrl #(.RES(RES), .NCH(NCH), .SAMPLE_CYC(SAMPLE_CYC)) i_sar_seq_ctrl (
    .clk, .rst, .cfg_en, .cfg_mode, .cfg_trig_sel, .cfg_ch_first, .cfg_ch_last,
    .sw_start, .tmr_tick, .cmp_high, .dac_code, .ch_sel, .sample_en, .conv_done,
    .seq_end, .busy, .overrun, .rd_idx, .rd_data
  );

  always @(negedge clk) begin
    if (!rst && conv_done) begin
      if (ncv < 1024) log_ch[ncv] = int'(ch_sel);
      ncv++;
    end
    if (!rst && seq_end) nse++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [1:0] m, input int f, input int l);
    return (m[1] && l > f) ? (l - f + 1) : 1;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rearm();
    @(negedge clk) cfg_en = 1'b0;
    @(negedge clk) cfg_en = 1'b1;
  endtask

  task automatic fire(input bit sel);
    @(negedge clk);
    if (sel) tmr_tick = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    tmr_tick = 1'b0;
    sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  task automatic rd(input int i, output int v);
    @(negedge clk) rd_idx = 3'(i);
    @(negedge clk) v = int'(rd_data);
  endtask

  task automatic run_pass(input logic [1:0] m, input int f, input int l,
                          input bit sel, input bit do_rearm, input string req);
    int b_cv, b_se, n, v;
    @(negedge clk);
    cfg_mode = m; cfg_ch_first = 3'(f); cfg_ch_last = 3'(l); cfg_trig_sel = sel;
    if (do_rearm) rearm();
    b_cv = ncv; b_se = nse;
    fire(sel);
    chk(busy == 1'b1, {req, " busy after trigger"}, int'(busy), 1);
    wait_idle();
    idle(1);
    n = exp_count(m, f, l);
    chk(ncv - b_cv == n, {req, " conversion count"}, ncv - b_cv, n);
    chk(nse - b_se == 1, {req, " seq_end count"}, nse - b_se, 1);
    for (int i = 0; i < n && i < NCH; i++) begin
      chk(log_ch[b_cv + i] == f + i, {req, " channel order"}, log_ch[b_cv + i], f + i);
      rd(i, v);
      chk(v == int'(vin[f + i]), {req, " R1 stored result"}, v, int'(vin[f + i]));
    end
  endtask

  task automatic new_inputs();
    for (int c = 0; c < NCH; c++) vin[c] = RES'($urandom);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt, first_at, first_code, b_cv, b_se;
    void'($urandom(32'd2024));
    new_inputs();
    idle(3);
    // R11 reset state
    chk(busy == 0 && conv_done == 0 && seq_end == 0, "R11 flags", int'(busy), 0);
    chk(overrun == 0 && sample_en == 0 && dac_code == 0, "R11 code", int'(dac_code), 0);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R2 latency and R1 first trial code
    cfg_mode = 2'd0; cfg_ch_first = 3'd3; cfg_trig_sel = 1'b0;
    rearm();
    @(negedge clk) sw_start = 1'b1;
    cnt = 0; first_at = 0; first_code = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk) sw_start = 1'b0;
      cnt++;
      if (dac_code != 0 && first_at == 0) begin first_at = cnt; first_code = int'(dac_code); end
      if (conv_done) break;
    end
    chk(cnt == SAMPLE_CYC + RES + 1, "R2 done latency", cnt, SAMPLE_CYC + RES + 1);
    chk(first_at == SAMPLE_CYC + 1, "R2 first trial edge", first_at, SAMPLE_CYC + 1);
    chk(first_code == (1 << (RES - 1)), "R1 msb first", first_code, 1 << (RES - 1));
    wait_idle();

    // R1 extremes
    vin[1] = '0;
    run_pass(2'd0, 1, 1, 1'b0, 1'b1, "R1 zero");
    vin[1] = '1;
    run_pass(2'd0, 1, 1, 1'b0, 1'b1, "R1 full");

    // R3 single once, then ignored without re-arm
    new_inputs();
    run_pass(2'd0, 6, 0, 1'b0, 1'b1, "R3");
    b_cv = ncv;
    fire(1'b0);
    idle(30);
    chk(ncv == b_cv && busy == 0, "R3 ignored after pass", ncv - b_cv, 0);
    chk(overrun == 0, "R3 no overrun when idle", int'(overrun), 0);

    // R4 single repeated stays armed
    run_pass(2'd1, 2, 7, 1'b0, 1'b1, "R4 first");
    new_inputs();
    run_pass(2'd1, 2, 7, 1'b0, 1'b0, "R4 again");

    // R5 range once, R6 range repeated
    run_pass(2'd2, 0, 7, 1'b0, 1'b1, "R5");
    run_pass(2'd3, 1, 4, 1'b1, 1'b1, "R6 first");
    new_inputs();
    run_pass(2'd3, 1, 4, 1'b1, 1'b0, "R6 again");

    // R10 reversed range
    run_pass(2'd2, 5, 2, 1'b0, 1'b1, "R10");

    // R7 source select
    @(negedge clk) cfg_mode = 2'd1; cfg_ch_first = 3'd0; cfg_trig_sel = 1'b1;
    rearm();
    b_cv = ncv;
    fire(1'b0);
    idle(25);
    chk(ncv == b_cv && busy == 0, "R7 strobe ignored on timer source", ncv - b_cv, 0);
    run_pass(2'd1, 0, 0, 1'b1, 1'b0, "R7 timer accepted");
    @(negedge clk) cfg_trig_sel = 1'b0;
    b_cv = ncv;
    fire(1'b1);
    idle(25);
    chk(ncv == b_cv && busy == 0, "R7 tick ignored on strobe source", ncv - b_cv, 0);

    // R8 overrun
    @(negedge clk) cfg_mode = 2'd2; cfg_ch_first = 3'd0; cfg_ch_last = 3'd7;
    rearm();
    b_cv = ncv;
    fire(1'b0);
    idle(6);
    fire(1'b0);
    chk(overrun == 1, "R8 overrun set", int'(overrun), 1);
    wait_idle();
    idle(1);
    chk(ncv - b_cv == 8, "R8 busy trigger ignored", ncv - b_cv, 8);
    chk(overrun == 1, "R8 overrun sticky", int'(overrun), 1);
    rearm();
    fire(1'b0);
    chk(overrun == 0, "R8 overrun cleared on accept", int'(overrun), 0);
    wait_idle();

    // R9 stop on enable low
    @(negedge clk) cfg_ch_first = 3'd2; cfg_ch_last = 3'd6;
    rearm();
    b_cv = ncv; b_se = nse;
    fire(1'b0);
    for (int k = 0; k < 50 && sample_en; k++) @(negedge clk);
    cfg_en = 1'b0;
    wait_idle();
    idle(2);
    chk(ncv - b_cv == 1, "R9 one conversion", ncv - b_cv, 1);
    chk(nse == b_se, "R9 no seq_end", nse - b_se, 0);
    b_cv = ncv;
    fire(1'b0);
    idle(25);
    chk(ncv == b_cv && busy == 0, "R9 disabled ignores trigger", ncv - b_cv, 0);

    // random passes (R5 R6 R3 R4 R10)
    for (int it = 0; it < 16; it++) begin
      logic [1:0] m;
      int f, l;
      m = 2'($urandom);
      f = int'($urandom % NCH);
      l = int'($urandom % NCH);
      new_inputs();
      run_pass(m, f, l, 1'($urandom), 1'b1, "R5 random pass");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule